// File: doc/BRIEF.md
# Infrared Power-Key Code Matcher

This block watches the output of an infrared receiver: the line idles high and the receiver pulls it low while a carrier burst is present. The block decodes pulse-distance frames of the common 32-bit consumer format. Each frame starts with a long low burst and a shorter high gap. Thirty-two bits follow, each a short low mark and then a high space whose length selects 0 or 1. A final short low mark closes the frame. The block times every low and high interval in prescaled ticks. It accepts an interval only when the interval falls inside a minimum/maximum window that software has programmed. Any interval outside its window abandons the frame.

A complete frame is compared against a small table of stored 32-bit key codes. When the frame equals a valid entry, a sticky key-hit status bit is set and an interrupt can be raised. The last completed frame is always available on a capture output. A short repeat frame (the leader burst followed by a shorter gap) sets the status again while the key is still held, provided the last full frame matched. Software configures the block through a simple write port: control bits, six timing windows, a valid mask and the key entries.

Top module: `ir_key_matcher`

## Requirements
- R1: After reset, status_o, irq_o and cap_code_o are 0 and the decoder waits in its idle state.
- R2: Interval lengths are counted in ticks of TICK_DIV clocks. Windows are inclusive and each is written as one word with the minimum in bits [15:0] and the maximum in bits [31:16]. The window addresses are: leader low 2, leader high 3, repeat gap 4, bit mark (low) 5, bit space for 0 at 6, bit space for 1 at 7. The space window for 0 takes precedence over the window for 1.
- R3: Bits are shifted in LSB first, so the first bit after the leader lands in bit 0. Every complete frame (leader, 32 bits, a closing mark in the bit-mark window) loads cap_code_o, whether or not it matches.
- R4: Key entry i (i < NKEYS) is written at address 16+i, and bit i of the valid mask at address 8 enables it. A complete frame equal to all 32 bits of a valid entry sets status_o.
- R5: A complete frame that differs from every valid entry, including one that differs by a single bit, leaves status_o at 0.
- R6: An entry whose valid bit is 0 never matches.
- R7: status_o is cleared by writing 1 to bit 0 of address 1. Writing 0 there leaves it unchanged. A new hit in the same cycle as the clear wins.
- R8: irq_o is status_o gated by bit 1 of the control word at address 0. The status bit is still set while that gate is 0.
- R9: While bit 0 of the control word (decode enable) is 0, frames are ignored: status_o and cap_code_o do not change.
- R10: An interval outside its window abandons the frame. This applies to a leader that is too long, a bit mark that is too long, and a space that falls between the 0 and 1 windows. An abandoned frame does not change status_o or cap_code_o.
- R11: A repeat frame is a leader low, then a high gap in the repeat window, then a closing mark. It sets status_o only when the last complete frame matched, and it leaves cap_code_o unchanged.
- R12: The decoder runs in order through idle, leader, address half (bits 0-15), command half (bits 16-31) and trailing-mark states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ir_i | input | 1 | Demodulated infrared line, idle high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register write address |
| wr_data_i | input | 32 | Register write data |
| cap_code_o | output | 32 | Last completed 32-bit frame |
| status_o | output | 1 | Sticky key-hit status |
| irq_o | output | 1 | Key-hit interrupt |

## Verification
The bench sends frames for every table entry. It then sweeps all 32 single-bit corruptions of one key, which catches a comparator that ignores some bits or a shift register that loads MSB first, since the capture would come back bit-reversed. A space placed between the 0 and 1 windows, and marks or leaders that run too long, must leave both the status and the capture untouched. A design that defaulted to a bit value or kept decoding would load a wrong code. Repeat frames are sent after both a matching and a non-matching frame, which exposes a repeat path that ignores the last match result. The valid mask, a 0-write to the status bit, and the enable and interrupt gates are each driven to the setting that must suppress a result.

// File: rtl/ir_key_pkg.sv
package ir_key_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PRELOAD = 3'd1,
    ST_USER    = 3'd2,
    ST_DATA    = 3'd3,
    ST_SEQ     = 3'd4
  } ir_state_e;

  localparam int A_CTRL     = 0;
  localparam int A_STAT     = 1;
  localparam int A_LEAD_LO  = 2;
  localparam int A_LEAD_HI  = 3;
  localparam int A_RPT      = 4;
  localparam int A_BIT_LO   = 5;
  localparam int A_BIT_ZERO = 6;
  localparam int A_BIT_ONE  = 7;
  localparam int A_VALID    = 8;
  localparam int A_KEY0     = 16;
endpackage

// File: rtl/ir_edge_timer.sv
module ir_edge_timer #(
  parameter int TICK_DIV = 100,
  parameter int TW       = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ir_i,
  output logic          level_o,
  output logic          edge_o,
  output logic [TW-1:0] dur_o,
  output logic          sat_o
);
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic s0_q, s1_q, prev_q;
  logic [DW-1:0] div_q;
  logic [TW-1:0] cnt_q;
  logic tick;

  assign tick    = (div_q == DW'(TICK_DIV - 1));
  assign edge_o  = s1_q ^ prev_q;
  assign level_o = s1_q;
  assign dur_o   = cnt_q;
  assign sat_o   = &cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_q   <= 1'b1;
      s1_q   <= 1'b1;
      prev_q <= 1'b1;
      div_q  <= '0;
      cnt_q  <= '0;
    end else begin
      s0_q   <= ir_i;
      s1_q   <= s0_q;
      prev_q <= s1_q;
      div_q  <= tick ? '0 : div_q + 1'b1;
      if (edge_o)               cnt_q <= '0;
      else if (tick && !sat_o)  cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ir_frame_fsm.sv
module ir_frame_fsm
  import ir_key_pkg::*;
#(
  parameter int TW  = 16,
  parameter int NB  = 32,
  localparam int BCW = $clog2(NB) + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            level_i,
  input  logic            edge_i,
  input  logic [TW-1:0]   dur_i,
  input  logic            sat_i,
  input  logic [2*TW-1:0] win_lead_lo_i,
  input  logic [2*TW-1:0] win_lead_hi_i,
  input  logic [2*TW-1:0] win_rpt_i,
  input  logic [2*TW-1:0] win_bit_lo_i,
  input  logic [2*TW-1:0] win_zero_i,
  input  logic [2*TW-1:0] win_one_i,
  output ir_state_e       state_o,
  output logic [BCW-1:0]  bit_cnt_o,
  output logic [NB-1:0]   code_o,
  output logic            code_done_o,
  output logic            rpt_done_o
);
  localparam int HALF = NB / 2;

  function automatic logic in_win(input logic [TW-1:0] d, input logic [2*TW-1:0] w);
    return (d >= w[TW-1:0]) && (d <= w[2*TW-1:TW]);
  endfunction

  ir_state_e      state_q;
  logic           phase_q;  // 0: low part, 1: high part
  logic           rpt_q;
  logic [BCW-1:0] cnt_q;
  logic [NB-1:0]  sh_q;
  logic           zero_ok, one_ok, lo_ok;

  assign lo_ok   = in_win(dur_i, win_bit_lo_i);
  assign zero_ok = in_win(dur_i, win_zero_i);
  assign one_ok  = in_win(dur_i, win_one_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      phase_q     <= 1'b0;
      rpt_q       <= 1'b0;
      cnt_q       <= '0;
      sh_q        <= '0;
      code_done_o <= 1'b0;
      rpt_done_o  <= 1'b0;
    end else begin
      code_done_o <= 1'b0;
      rpt_done_o  <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
      end else if (state_q != ST_IDLE && sat_i && !edge_i) begin
        state_q <= ST_IDLE;
      end else if (edge_i) begin
        case (state_q)
          ST_IDLE: if (!level_i) begin
            state_q <= ST_PRELOAD;
            phase_q <= 1'b0;
            rpt_q   <= 1'b0;
          end
          ST_PRELOAD: begin
            if (!phase_q) begin
              if (in_win(dur_i, win_lead_lo_i)) phase_q <= 1'b1;
              else                              state_q <= ST_IDLE;
            end else if (in_win(dur_i, win_lead_hi_i)) begin
              state_q <= ST_USER;
              phase_q <= 1'b0;
              cnt_q   <= '0;
            end else if (in_win(dur_i, win_rpt_i)) begin
              state_q <= ST_SEQ;
              rpt_q   <= 1'b1;
            end else begin
              state_q <= ST_IDLE;
            end
          end
          ST_USER, ST_DATA: begin
            if (!phase_q) begin
              if (lo_ok) phase_q <= 1'b1;
              else       state_q <= ST_IDLE;
            end else if (zero_ok || one_ok) begin
              sh_q    <= {!zero_ok, sh_q[NB-1:1]};
              cnt_q   <= cnt_q + 1'b1;
              phase_q <= 1'b0;
              if (cnt_q == BCW'(HALF - 1)) state_q <= ST_DATA;
              if (cnt_q == BCW'(NB - 1))   state_q <= ST_SEQ;
            end else begin
              state_q <= ST_IDLE;
            end
          end
          ST_SEQ: begin
            if (lo_ok) begin
              if (rpt_q) rpt_done_o  <= 1'b1;
              else       code_done_o <= 1'b1;
            end
            state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign state_o   = state_q;
  assign bit_cnt_o = cnt_q;
  assign code_o    = sh_q;
endmodule

// File: rtl/ir_key_table.sv
module ir_key_table #(
  parameter int NKEYS = 10,
  parameter int NB    = 32,
  localparam int IW   = (NKEYS > 1) ? $clog2(NKEYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic [NB-1:0]    wr_data_i,
  input  logic [NKEYS-1:0] valid_i,
  input  logic [NB-1:0]    code_i,
  output logic             hit_o
);
  logic [NKEYS-1:0] eq;

  for (genvar i = 0; i < NKEYS; i++) begin : g_key
    logic [NB-1:0] key_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             key_q <= '0;
      else if (wr_i && wr_idx_i == IW'(i))     key_q <= wr_data_i;
    end
    assign eq[i] = valid_i[i] && (key_q == code_i);
  end

  assign hit_o = |eq;
endmodule

// File: rtl/ir_key_matcher.sv
module ir_key_matcher
  import ir_key_pkg::*;
#(
  parameter int TICK_DIV = 100,
  parameter int TW       = 16,
  parameter int NKEYS    = 10,
  parameter int AW       = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ir_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [31:0]   wr_data_i,
  output logic [31:0]   cap_code_o,
  output logic          status_o,
  output logic          irq_o
);
  localparam int NB  = 32;
  localparam int BCW = $clog2(NB) + 1;
  localparam int IW  = (NKEYS > 1) ? $clog2(NKEYS) : 1;

  logic key_en, irq_en, status_q, last_match;
  logic [2*TW-1:0] w_lead_lo, w_lead_hi, w_rpt, w_bit_lo, w_zero, w_one;
  logic [NKEYS-1:0] valid_q;
  logic [NB-1:0] cap_q, code;
  logic level, edge_s, sat, code_done, rpt_done, hit, key_wr;
  logic [TW-1:0] dur;
  ir_state_e state;
  logic [BCW-1:0] bit_cnt;
  logic [AW-1:0] key_off;

  ir_edge_timer #(.TICK_DIV(TICK_DIV), .TW(TW)) u_timer (
    .clk_i, .rst_ni, .ir_i,
    .level_o(level), .edge_o(edge_s), .dur_o(dur), .sat_o(sat)
  );

  ir_frame_fsm #(.TW(TW), .NB(NB)) u_fsm (
    .clk_i, .rst_ni, .en_i(key_en),
    .level_i(level), .edge_i(edge_s), .dur_i(dur), .sat_i(sat),
    .win_lead_lo_i(w_lead_lo), .win_lead_hi_i(w_lead_hi), .win_rpt_i(w_rpt),
    .win_bit_lo_i(w_bit_lo), .win_zero_i(w_zero), .win_one_i(w_one),
    .state_o(state), .bit_cnt_o(bit_cnt), .code_o(code),
    .code_done_o(code_done), .rpt_done_o(rpt_done)
  );

  assign key_off = wr_addr_i - AW'(A_KEY0);
  assign key_wr  = wr_en_i && (wr_addr_i >= AW'(A_KEY0)) && (key_off < AW'(NKEYS));

  ir_key_table #(.NKEYS(NKEYS), .NB(NB)) u_table (
    .clk_i, .rst_ni, .wr_i(key_wr), .wr_idx_i(key_off[IW-1:0]),
    .wr_data_i(wr_data_i), .valid_i(valid_q), .code_i(code), .hit_o(hit)
  );

  // configuration; defaults assume one tick per microsecond
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_en    <= 1'b0;
      irq_en    <= 1'b0;
      valid_q   <= '0;
      w_lead_lo <= {TW'(10000), TW'(8000)};
      w_lead_hi <= {TW'(5000),  TW'(4000)};
      w_rpt     <= {TW'(2500),  TW'(2000)};
      w_bit_lo  <= {TW'(730),   TW'(390)};
      w_zero    <= {TW'(730),   TW'(390)};
      w_one     <= {TW'(2000),  TW'(1300)};
    end else if (wr_en_i) begin
      case (wr_addr_i)
        AW'(A_CTRL):     {irq_en, key_en} <= wr_data_i[1:0];
        AW'(A_LEAD_LO):  w_lead_lo <= wr_data_i[2*TW-1:0];
        AW'(A_LEAD_HI):  w_lead_hi <= wr_data_i[2*TW-1:0];
        AW'(A_RPT):      w_rpt     <= wr_data_i[2*TW-1:0];
        AW'(A_BIT_LO):   w_bit_lo  <= wr_data_i[2*TW-1:0];
        AW'(A_BIT_ZERO): w_zero    <= wr_data_i[2*TW-1:0];
        AW'(A_BIT_ONE):  w_one     <= wr_data_i[2*TW-1:0];
        AW'(A_VALID):    valid_q   <= wr_data_i[NKEYS-1:0];
        default: ;
      endcase
    end
  end

  // status: set wins over write-1-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q   <= 1'b0;
      last_match <= 1'b0;
      cap_q      <= '0;
    end else begin
      if ((code_done && hit) || (rpt_done && last_match))
        status_q <= 1'b1;
      else if (wr_en_i && wr_addr_i == AW'(A_STAT) && wr_data_i[0])
        status_q <= 1'b0;
      if (code_done) begin
        last_match <= hit;
        cap_q      <= code;
      end
    end
  end

  assign status_o   = status_q;
  assign irq_o      = status_q & irq_en;
  assign cap_code_o = cap_q;
endmodule

// File: rtl/ir_key_matcher_chk.sv
module ir_key_matcher_chk
  import ir_key_pkg::*;
#(
  parameter int AW  = 5,
  parameter int NB  = 32,
  localparam int BCW = $clog2(NB) + 1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input ir_state_e      state,
  input logic [BCW-1:0] bit_cnt,
  input logic           code_done,
  input logic           rpt_done,
  input logic           key_en,
  input logic           wr_en_i,
  input logic [AW-1:0]  wr_addr_i,
  input logic [31:0]    wr_data_i,
  input logic [31:0]    cap_code_o,
  input logic           status_o,
  input logic           irq_o
);
  a_r12_user_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_USER |-> bit_cnt < BCW'(NB / 2));
  a_r12_data_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_DATA |-> bit_cnt >= BCW'(NB / 2));
  a_r12_user_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_USER && $past(state) != ST_USER) |-> $past(state) == ST_PRELOAD);
  a_r12_data_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_DATA && $past(state) != ST_DATA) |-> $past(state) == ST_USER);
  a_r4_status_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o) |-> $past(code_done || rpt_done));
  a_r3_cap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(code_done) |-> $stable(cap_code_o));
  a_r9_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_en |=> state == ST_IDLE);
  a_r7_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == AW'(A_STAT) && wr_data_i[0] && !code_done && !rpt_done) |=> !status_o);
  a_r8_irq_needs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> status_o);
endmodule

bind ir_key_matcher ir_key_matcher_chk #(.AW(AW), .NB(NB)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .state(state), .bit_cnt(bit_cnt),
  .code_done(code_done), .rpt_done(rpt_done), .key_en(key_en),
  .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
  .cap_code_o(cap_code_o), .status_o(status_o), .irq_o(irq_o)
);

// File: tb/ir_key_matcher_test.sv
module ir_key_matcher_test;
  import ir_key_pkg::*;
  localparam int NK = 10;
  // windows in ticks (one tick = 2 clocks)
  localparam int T_LL = 24, T_LH = 12, T_RP = 6, T_BL = 3, T_B0 = 3, T_B1 = 9;

  logic clk = 1'b0, rst_n = 1'b0, ir = 1'b1, wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] cap;
  logic status, irq;
  int n_run = 0, n_fail = 0;
  logic [31:0] keys [NK];
  logic [NK-1:0] vmask;
  logic [31:0] cap_exp;
  logic last_m;

  always #5 clk = ~clk;

  ir_key_matcher #(.TICK_DIV(2), .TW(16), .NKEYS(NK), .AW(5)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ir_i(ir), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .cap_code_o(cap), .status_o(status), .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic hold(logic lvl, int t);
    ir = lvl;
    repeat (2 * t) @(negedge clk);
  endtask

  function automatic logic exp_hit(logic [31:0] c);
    for (int i = 0; i < NK; i++) if (vmask[i] && keys[i] == c) return 1'b1;
    return 1'b0;
  endfunction

  // kind 0 good, 1 long leader, 2 space between windows at bit 20, 3 long mark at bit 5
  task automatic send(logic [31:0] c, int kind);
    hold(1'b0, kind == 1 ? 40 : T_LL);
    hold(1'b1, T_LH);
    for (int b = 0; b < 32; b++) begin
      hold(1'b0, (kind == 3 && b == 5) ? 8 : T_BL);
      hold(1'b1, (kind == 2 && b == 20) ? 6 : (c[b] ? T_B1 : T_B0));
    end
    hold(1'b0, T_BL);
    hold(1'b1, 20);
  endtask

  task automatic send_rpt();
    hold(1'b0, T_LL);
    hold(1'b1, T_RP);
    hold(1'b0, T_BL);
    hold(1'b1, 20);
  endtask

  // good frame with decode enabled; updates the model
  task automatic good(logic [31:0] c);
    send(c, 0);
    cap_exp = c;
    last_m  = exp_hit(c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 status", 32'(status), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 cap", cap, 0);

    // R2 window programming: min in [15:0], max in [31:16]
    wr(A_LEAD_LO,  {16'd28, 16'd20});
    wr(A_LEAD_HI,  {16'd14, 16'd10});
    wr(A_RPT,      {16'd7,  16'd5});
    wr(A_BIT_LO,   {16'd4,  16'd2});
    wr(A_BIT_ZERO, {16'd4,  16'd2});
    wr(A_BIT_ONE,  {16'd11, 16'd8});
    for (int i = 0; i < NK; i++) begin
      keys[i] = 32'h3C00C300 + 32'(i) * 32'h01010011;
      wr(A_KEY0 + i, keys[i]);
    end
    vmask = '1;
    wr(A_VALID, 32'(vmask));
    wr(A_CTRL, 32'h3);
    cap_exp = '0;
    last_m = 1'b0;

    // R4 every entry matches
    for (int i = 0; i < NK; i++) begin
      good(keys[i]);
      check($sformatf("R4 key %0d status", i), 32'(status), 1);
      check("R8 irq follows status", 32'(irq), 1);
      check("R3 R2 cap of matching frame", cap, cap_exp);
      wr(A_STAT, 32'h0);
      check("R7 write 0 keeps status", 32'(status), 1);
      wr(A_STAT, 32'h1);
      check("R7 write 1 clears", 32'(status), 0);
    end

    // R3 LSB-first ordering on asymmetric patterns
    good(32'h00000001);
    check("R3 lsb first", cap, 32'h00000001);
    good(32'h80000000);
    check("R3 msb last", cap, 32'h80000000);
    good(32'hFFFFFFFF);
    check("R3 all ones", cap, 32'hFFFFFFFF);

    // R5 single-bit corruption sweep of key 3
    for (int b = 0; b < 32; b++) begin
      logic [31:0] c;
      c = keys[3] ^ (32'h1 << b);
      good(c);
      check($sformatf("R5 flip bit %0d status", b), 32'(status), 32'(exp_hit(c)));
      check("R3 cap of flipped frame", cap, c);
      if (status) wr(A_STAT, 1);
    end

    // R11 repeat after non-matching frame: no status
    send_rpt();
    check("R11 repeat after miss", 32'(status), 0);
    // R11 repeat after matching frame
    good(keys[0]);
    wr(A_STAT, 1);
    send_rpt();
    check("R11 repeat after hit", 32'(status), 1);
    check("R11 repeat keeps cap", cap, keys[0]);
    wr(A_STAT, 1);

    // R6 invalid entry
    vmask[5] = 1'b0;
    wr(A_VALID, 32'(vmask));
    good(keys[5]);
    check("R6 invalid entry no match", 32'(status), 0);
    check("R6 cap still loads", cap, keys[5]);

    // R10 abandoned frames
    send(keys[1], 1);
    check("R10 long leader status", 32'(status), 0);
    check("R10 long leader cap", cap, cap_exp);
    send(keys[1], 2);
    check("R10 space between windows status", 32'(status), 0);
    check("R10 space between windows cap", cap, cap_exp);
    send(keys[1], 3);
    check("R10 long mark status", 32'(status), 0);
    check("R10 long mark cap", cap, cap_exp);

    // R8 interrupt gate
    wr(A_CTRL, 32'h1);
    good(keys[2]);
    check("R8 status with gate off", 32'(status), 1);
    check("R8 irq gated off", 32'(irq), 0);
    wr(A_STAT, 1);

    // R9 decode disabled
    wr(A_CTRL, 32'h2);
    send(keys[4], 0);
    check("R9 disabled status", 32'(status), 0);
    check("R9 disabled cap", cap, cap_exp);
    check("R9 disabled irq", 32'(irq), 0);
    wr(A_CTRL, 32'h3);
    good(keys[4]);
    check("R9 re-enabled match", 32'(status), 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule